// File: doc/BRIEF.md
# Multi-mode checksum engine

This block folds a stream of 32-bit data words into one running checksum. A single 32-bit accumulator serves six algorithms: CRC-32 and CRC-16-CCITT, each fed either most-significant bit first or least-significant bit first, a wrapping 32-bit sum, and even parity. Each cycle with a valid word advances the accumulator by one full word.

Software controls the block through two register writes. The first sets the algorithm and the output options. The second loads a seed value straight into the accumulator. The result port always shows the accumulator after optional output transforms: bit reversal, then byte swap, then inversion. These transforms shape only the value that is read out. The stored value is never changed by them, so a sequence can resume after any read.

Top module: `cksum_engine`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0, selects CRC-32 most-significant-bit-first (code 0), and turns all output transforms off.
- R2: In mode code 0, each valid word is fed into a CRC with polynomial 0x04C11DB7 over all 32 accumulator bits, starting from data bit 31 and ending with bit 0.
- R3: In mode code 1, each valid word is fed into a right-shifting CRC with the reflected polynomial 0xEDB88320, starting from data bit 0 and ending with bit 31.
- R4: In mode code 2, each valid word is fed, from bit 31 down to bit 0, into a 16-bit CRC with polynomial 0x1021 held in accumulator bits 15:0, and bits 31:16 become 0.
- R5: In mode code 3, each valid word is fed, from bit 0 up to bit 31, into a right-shifting 16-bit CRC with polynomial 0x8408 in bits 15:0, and bits 31:16 become 0.
- R6: In mode code 4, each valid word is added to the accumulator modulo 2^32.
- R7: In mode code 5, accumulator bit 0 becomes its old value XOR the parity of the word, and bits 31:1 become 0.
- R8: A seed write loads the seed value into the accumulator at the next clock edge. This write wins over a valid word in the same cycle.
- R9: The accumulator holds its value in a cycle with no valid word and no seed write. It also holds when the mode code is 6 or 7.
- R10: A configuration write takes effect from the following cycle. A valid word in the same cycle as the write is still processed with the previous mode.
- R11: The result is the accumulator after three optional steps, applied in this order: bit reversal (when the reverse flag is set), then byte swap (when the swap flag is set), then bitwise inversion (when the invert flag is set). Clearing all flags shows the unchanged accumulator again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_mode | input | 3 | Algorithm code: 0 to 5 as listed in the requirements; 6 and 7 hold the accumulator |
| cfg_rev | input | 1 | Output bit-reverse flag |
| cfg_swap | input | 1 | Output byte-swap flag |
| cfg_inv | input | 1 | Output invert flag |
| seed_we | input | 1 | Seed write strobe |
| seed_val | input | 32 | Value loaded into the accumulator |
| in_valid | input | 1 | Data word is valid this cycle |
| in_data | input | 32 | Data word |
| result | output | 32 | Transformed accumulator value |

## Verification
The assertions check the following on every cycle:
- a seed write wins over data;
- the accumulator holds when idle or when an unused mode code is selected;
- the sum wraps;
- parity and the 16-bit CRC modes leave the upper bits at zero;
- with no flags set, the result equals the accumulator.

The bench scenarios cover what those checks cannot. They confirm that the CRC values are correct for each polynomial and bit order. The reference model for the bit-reversed modes uses a reflection identity rather than a right-shifting register. The scenarios also check that a configuration write lags by one cycle, and that the output transforms apply in the stated order without disturbing the stored value.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

    localparam int unsigned ACC_W  = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned BYTES  = ACC_W / 8;

    localparam logic [ACC_W-1:0]  POLY32     = 32'h04C11DB7;
    localparam logic [ACC_W-1:0]  POLY32_REF = 32'hEDB88320;
    localparam logic [HALF_W-1:0] POLY16     = 16'h1021;
    localparam logic [HALF_W-1:0] POLY16_REF = 16'h8408;

    typedef enum logic [2:0] {
        MODE_CRC32_MSB = 3'd0,
        MODE_CRC32_LSB = 3'd1,
        MODE_CRC16_MSB = 3'd2,
        MODE_CRC16_LSB = 3'd3,
        MODE_SUM       = 3'd4,
        MODE_PARITY    = 3'd5
    } cks_mode_e;

    typedef struct packed {
        cks_mode_e mode;
        logic      rev;
        logic      swap;
        logic      inv;
    } cks_cfg_t;

    localparam cks_cfg_t CFG_RESET = '{mode: MODE_CRC32_MSB, rev: 1'b0, swap: 1'b0, inv: 1'b0};

    // Left-shifting 32-bit CRC, data fed from bit 31 down
    function automatic logic [ACC_W-1:0] crc32_fwd(input logic [ACC_W-1:0] c,
                                                    input logic [ACC_W-1:0] d);
        logic [ACC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = ACC_W - 1; i >= 0; i--) begin
            fb = r[ACC_W-1] ^ d[i];
            r  = {r[ACC_W-2:0], 1'b0} ^ (fb ? POLY32 : '0);
        end
        return r;
    endfunction

    // Right-shifting 32-bit CRC, data fed from bit 0 up
    function automatic logic [ACC_W-1:0] crc32_ref(input logic [ACC_W-1:0] c,
                                                    input logic [ACC_W-1:0] d);
        logic [ACC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < int'(ACC_W); i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[ACC_W-1:1]} ^ (fb ? POLY32_REF : '0);
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] crc16_fwd(input logic [HALF_W-1:0] c,
                                                     input logic [ACC_W-1:0] d);
        logic [HALF_W-1:0] r;
        logic fb;
        r = c;
        for (int i = ACC_W - 1; i >= 0; i--) begin
            fb = r[HALF_W-1] ^ d[i];
            r  = {r[HALF_W-2:0], 1'b0} ^ (fb ? POLY16 : '0);
        end
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] crc16_ref(input logic [HALF_W-1:0] c,
                                                     input logic [ACC_W-1:0] d);
        logic [HALF_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < int'(ACC_W); i++) begin
            fb = r[0] ^ d[i];
            r  = {1'b0, r[HALF_W-1:1]} ^ (fb ? POLY16_REF : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/cksum_cfg_reg.sv
module cksum_cfg_reg
    import cksum_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  cks_cfg_t wr_cfg,
    output cks_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)     cfg_q <= CFG_RESET;
        else if (we) cfg_q <= wr_cfg;
    end
endmodule

// File: rtl/cksum_next.sv
module cksum_next
    import cksum_pkg::*;
(
    input  cks_mode_e        mode,
    input  logic [ACC_W-1:0] acc,
    input  logic [ACC_W-1:0] data,
    output logic [ACC_W-1:0] nxt,
    output logic             known
);
    always_comb begin
        nxt   = acc;
        known = 1'b1;
        unique case (mode)
            MODE_CRC32_MSB: nxt = crc32_fwd(acc, data);
            MODE_CRC32_LSB: nxt = crc32_ref(acc, data);
            MODE_CRC16_MSB: nxt = {{(ACC_W-HALF_W){1'b0}}, crc16_fwd(acc[HALF_W-1:0], data)};
            MODE_CRC16_LSB: nxt = {{(ACC_W-HALF_W){1'b0}}, crc16_ref(acc[HALF_W-1:0], data)};
            MODE_SUM:       nxt = acc + data;
            MODE_PARITY:    nxt = {{(ACC_W-1){1'b0}}, acc[0] ^ (^data)};
            default:        known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cksum_acc.sv
module cksum_acc
    import cksum_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed_we,
    input  logic [ACC_W-1:0] seed,
    input  logic             adv,
    input  logic [ACC_W-1:0] nxt,
    output logic [ACC_W-1:0] acc_q
);
    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (seed_we) acc_q <= seed;
        else if (adv)     acc_q <= nxt;
    end
endmodule

// File: rtl/cksum_outfmt.sv
module cksum_outfmt
    import cksum_pkg::*;
(
    input  logic [ACC_W-1:0] acc,
    input  logic             rev,
    input  logic             swap,
    input  logic             inv,
    output logic [ACC_W-1:0] y
);
    logic [ACC_W-1:0] reversed;
    logic [ACC_W-1:0] swapped;
    logic [ACC_W-1:0] s1;
    logic [ACC_W-1:0] s2;

    for (genvar b = 0; b < ACC_W; b++) begin : g_rev
        assign reversed[b] = acc[ACC_W-1-b];
    end

    assign s1 = rev ? reversed : acc;

    for (genvar k = 0; k < BYTES; k++) begin : g_swap
        assign swapped[8*k +: 8] = s1[8*(BYTES-1-k) +: 8];
    end

    assign s2 = swap ? swapped : s1;
    assign y  = inv ? ~s2 : s2;
endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
    import cksum_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_mode,
    input  logic        cfg_rev,
    input  logic        cfg_swap,
    input  logic        cfg_inv,
    input  logic        seed_we,
    input  logic [31:0] seed_val,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic [31:0] result
);
    cks_cfg_t         wr_cfg;
    cks_cfg_t         cfg_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] nxt;
    logic             known;

    assign wr_cfg = '{mode: cks_mode_e'(cfg_mode), rev: cfg_rev, swap: cfg_swap, inv: cfg_inv};

    cksum_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q)
    );

    cksum_next u_next (
        .mode  (cfg_q.mode),
        .acc   (acc_q),
        .data  (in_data),
        .nxt   (nxt),
        .known (known)
    );

    cksum_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .seed_we (seed_we),
        .seed    (seed_val),
        .adv     (in_valid && known),
        .nxt     (nxt),
        .acc_q   (acc_q)
    );

    cksum_outfmt u_out (
        .acc  (acc_q),
        .rev  (cfg_q.rev),
        .swap (cfg_q.swap),
        .inv  (cfg_q.inv),
        .y    (result)
    );
endmodule

// File: rtl/cksum_engine_chk.sv
module cksum_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        seed_we,
    input logic [31:0] seed_val,
    input logic        in_valid,
    input logic [31:0] in_data,
    input logic [31:0] acc,
    input logic [2:0]  mode,
    input logic        f_rev,
    input logic        f_swap,
    input logic        f_inv,
    input logic [31:0] result
);
    logic live;
    assign live = in_valid && !seed_we;

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (rst)
        seed_we |=> acc == $past(seed_val)); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!seed_we && !in_valid) |=> $stable(acc)); // R9
    AST_HOLD_BADMODE: assert property (@(posedge clk) disable iff (rst)
        (live && mode >= 3'd6) |=> $stable(acc)); // R9
    AST_SUM_WRAP: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 3'd4) |=> acc == $past(acc) + $past(in_data)); // R6
    AST_PARITY_BIT: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 3'd5) |=> (acc[31:1] == 31'd0) &&
                                    (acc[0] == ($past(acc[0]) ^ (^$past(in_data))))); // R7
    AST_CRC16_MSB_UPPER: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 3'd2) |=> acc[31:16] == 16'd0); // R4
    AST_CRC16_LSB_UPPER: assert property (@(posedge clk) disable iff (rst)
        (live && mode == 3'd3) |=> acc[31:16] == 16'd0); // R5
    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (rst)
        (!f_rev && !f_swap && !f_inv) |-> result == acc); // R11
endmodule

bind cksum_engine cksum_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .seed_we  (seed_we),
    .seed_val (seed_val),
    .in_valid (in_valid),
    .in_data  (in_data),
    .acc      (acc_q),
    .mode     (cfg_q.mode),
    .f_rev    (cfg_q.rev),
    .f_swap   (cfg_q.swap),
    .f_inv    (cfg_q.inv),
    .result   (result)
);

// File: tb/tb_cksum_engine.sv
module tb_cksum_engine;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_mode;
    logic        cfg_rev, cfg_swap, cfg_inv;
    logic        seed_we;
    logic [31:0] seed_val;
    logic        in_valid;
    logic [31:0] in_data;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_acc;
    logic [2:0]  m_mode;
    logic        m_rev, m_swap, m_inv;

    always #5 clk = ~clk;

    cksum_engine dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_rev(cfg_rev), .cfg_swap(cfg_swap), .cfg_inv(cfg_inv),
        .seed_we(seed_we), .seed_val(seed_val), .in_valid(in_valid),
        .in_data(in_data), .result(result)
    );

    function automatic logic [31:0] rv32(input logic [31:0] x);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = x[31-i];
        return r;
    endfunction

    function automatic logic [15:0] rv16(input logic [15:0] x);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = x[15-i];
        return r;
    endfunction

    function automatic logic [31:0] m_crc32(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        logic b;
        r = c;
        for (int k = 0; k < 32; k++) begin
            b = d[31-k] ^ r[31];
            r = (r << 1) ^ (b ? 32'h04C11DB7 : 32'h0);
        end
        return r;
    endfunction

    function automatic logic [15:0] m_crc16(input logic [15:0] c, input logic [31:0] d);
        logic [15:0] r;
        logic b;
        r = c;
        for (int k = 0; k < 32; k++) begin
            b = d[31-k] ^ r[15];
            r = (r << 1) ^ (b ? 16'h1021 : 16'h0);
        end
        return r;
    endfunction

    // Bit-0-first variants obtained by reflecting state and data
    function automatic logic [31:0] model_next(input logic [2:0] md, input logic [31:0] a,
                                               input logic [31:0] d);
        case (md)
            3'd0: return m_crc32(a, d);
            3'd1: return rv32(m_crc32(rv32(a), rv32(d)));
            3'd2: return {16'h0, m_crc16(a[15:0], d)};
            3'd3: return {16'h0, rv16(m_crc16(rv16(a[15:0]), rv32(d)))};
            3'd4: return a + d;
            3'd5: return {31'h0, a[0] ^ (^d)};
            default: return a;
        endcase
    endfunction

    function automatic logic [31:0] model_out(input logic [31:0] a, input logic r,
                                              input logic s, input logic v);
        logic [31:0] x;
        x = r ? rv32(a) : a;
        if (s) x = {x[7:0], x[15:8], x[23:16], x[31:24]};
        if (v) x = ~x;
        return x;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: result=%08h expected=%08h", req, got, exp);
        end
    endtask

    // Drive at negedge, let one edge pass, update the model, compare at next negedge
    task automatic cyc(input logic cw, input logic [2:0] md, input logic r, input logic s,
                       input logic v, input logic sw, input logic [31:0] sv,
                       input logic dv, input logic [31:0] d, input string req);
        cfg_we = cw; cfg_mode = md; cfg_rev = r; cfg_swap = s; cfg_inv = v;
        seed_we = sw; seed_val = sv; in_valid = dv; in_data = d;
        @(posedge clk);
        if (sw)      m_acc = sv;
        else if (dv) m_acc = model_next(m_mode, m_acc, d);
        if (cw) begin m_mode = md; m_rev = r; m_swap = s; m_inv = v; end
        @(negedge clk);
        check(req, result, model_out(m_acc, m_rev, m_swap, m_inv));
    endtask

    task automatic setcfg(input logic [2:0] md, input logic r, input logic s, input logic v,
                          input string req);
        cyc(1'b1, md, r, s, v, 1'b0, 32'h0, 1'b0, 32'h0, req);
    endtask

    task automatic seed(input logic [31:0] sv, input string req);
        cyc(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, sv, 1'b0, 32'h0, req);
    endtask

    task automatic feed(input logic [31:0] d, input string req);
        cyc(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1, d, req);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: result=%08h expected=run complete", result);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; cfg_we = 0; cfg_mode = 0; cfg_rev = 0; cfg_swap = 0; cfg_inv = 0;
        seed_we = 0; seed_val = 0; in_valid = 0; in_data = 0;
        m_acc = 0; m_mode = 0; m_rev = 0; m_swap = 0; m_inv = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset accumulator", result, 32'h0);

        // R1/R2: default mode is CRC-32 bit 31 first
        feed(32'h12345678, "R1 R2 default mode");
        seed(32'hFFFFFFFF, "R8 seed");
        feed(32'h00000000, "R2 crc32 msb zeros");
        feed(32'hDEADBEEF, "R2 crc32 msb word");

        setcfg(3'd1, 0, 0, 0, "R10 cfg lsb32");
        seed(32'hFFFFFFFF, "R8 seed");
        feed(32'h00000001, "R3 crc32 lsb");
        feed(32'hCAFEF00D, "R3 crc32 lsb word");

        setcfg(3'd2, 0, 0, 0, "R10 cfg msb16");
        seed(32'hABCD1234, "R8 seed");
        feed(32'h80000000, "R4 crc16 msb upper cleared");
        feed(32'h31323334, "R4 crc16 msb word");

        setcfg(3'd3, 0, 0, 0, "R10 cfg lsb16");
        seed(32'h0000FFFF, "R8 seed");
        feed(32'h00000001, "R5 crc16 lsb");
        feed(32'h5A5AA5A5, "R5 crc16 lsb word");

        setcfg(3'd4, 0, 0, 0, "R10 cfg sum");
        seed(32'hFFFFFFF0, "R8 seed");
        feed(32'h00000020, "R6 sum wrap");
        check("R6 sum wrap explicit", result, 32'h00000010);

        // R8: seed beats a valid word in the same cycle
        cyc(0, 0, 0, 0, 0, 1'b1, 32'h13579BDF, 1'b1, 32'h11111111, "R8 seed wins");
        check("R8 seed wins explicit", result, 32'h13579BDF);

        // R10: config write in the same cycle as data uses the old (sum) mode
        cyc(1'b1, 3'd5, 0, 0, 0, 1'b0, 32'h0, 1'b1, 32'h00000003, "R10 old mode used");
        check("R10 old mode explicit", result, 32'h13579BE2);
        seed(32'h0, "R8 seed");
        feed(32'h00000007, "R7 parity odd");
        check("R7 parity explicit", result, 32'h00000001);
        feed(32'h00000003, "R7 parity even word");
        feed(32'hFFFFFFFE, "R7 parity upper zero");

        // R9: hold when idle, and with codes 6 and 7
        cyc(0, 0, 0, 0, 0, 0, 32'h0, 0, 32'hFFFFFFFF, "R9 idle hold");
        setcfg(3'd6, 0, 0, 0, "R10 cfg code6");
        feed(32'h12345678, "R9 code6 hold");
        setcfg(3'd7, 0, 0, 0, "R10 cfg code7");
        feed(32'h87654321, "R9 code7 hold");

        // R11: transforms
        seed(32'h00000001, "R8 seed");
        setcfg(3'd7, 1, 0, 0, "R11 reverse");
        check("R11 reverse explicit", result, 32'h80000000);
        setcfg(3'd7, 1, 1, 1, "R11 all");
        check("R11 order explicit", result, 32'hFFFFFF7F);
        seed(32'h11223344, "R8 seed");
        setcfg(3'd7, 0, 1, 0, "R11 swap");
        check("R11 swap explicit", result, 32'h44332211);
        setcfg(3'd7, 0, 0, 1, "R11 invert");
        check("R11 invert explicit", result, 32'hEEDDCCBB);
        setcfg(3'd7, 0, 0, 0, "R11 cleared");
        check("R11 stored untouched", result, 32'h11223344);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic cw, sw, dv;
            logic [2:0] md;
            string req;
            cw = ($urandom % 10) == 0;
            sw = ($urandom % 12) == 0;
            dv = ($urandom % 4) != 0;
            md = ($urandom % 16 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
            case (m_mode)
                3'd0: req = "R2 random";
                3'd1: req = "R3 random";
                3'd2: req = "R4 random";
                3'd3: req = "R5 random";
                3'd4: req = "R6 random";
                3'd5: req = "R7 random";
                default: req = "R9 random";
            endcase
            if (sw) req = "R8 random";
            if (cw) req = {req, " R10"};
            cyc(cw, md, 1'($urandom), 1'($urandom), 1'($urandom), sw, $urandom,
                dv, $urandom, req);
        end

        done = 1'b1;
        finish_run();
    end
endmodule